// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital side of an 8-bit successive-approximation converter with four analog inputs. Software uses a small register bus with three registers. The control word turns the converter on, starts a conversion, chooses the input channel, chooses the conversion clock and holds the completion flag. The result register holds the converted value. The pin-use register sets which of the four shared pins are analog. The analog multiplexer, the comparator, the trial DAC and the reference sit outside the block.

During a conversion the block drives an 8-bit trial code to the DAC and reads one comparator bit that says whether the input is at or above that code. It resolves one bit per conversion-clock period, starting with the MSB, so a conversion lasts eight periods. The conversion clock is the system clock divided by 2, 8 or 32. An automatic setting picks the ratio from the oscillator mode. When the conversion ends, the start bit clears itself and the completion flag is set.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word, the pin-use register and the result register all read 0, `dac_code` is 0, all four pins are analog and `ext_ref` is 0.
- R2: A control write with the start bit (bit 2) at 1 and the enable bit (bit 0) at 0 starts nothing: bit 2 reads 0 and the flag (bit 1) stays 0.
- R3: A control write with bits 0 and 2 set starts a conversion. The block tries bit 7 first (`dac_code` = 0x80) and keeps a trial bit when `cmp_above` is 1. Bit 2 reads 1 until 8·N clock edges after the write edge, where N is the divide ratio. At that edge bit 2 reads 0 and the result register (address 1) holds the converted code.
- R4: The flag (bit 1) is set at the edge where a conversion completes. Writing 0 to bit 1 clears it. Writing 1 to bit 1 has no effect.
- R5: Control bits 4:3 drive `chan_sel` (00 is input 0 through 11 is input 3). Bit 5 is a free read/write bit.
- R6: Control bits 7:6 pick the conversion clock: 00 gives a ratio of 2, 01 gives 8 and 10 gives 32.
- R7: Control bits 7:6 at 11 select the automatic ratio from `osc_mode`: 11 (fast crystal) gives 32, 10 (standard crystal) gives 8, and 00 (RC) or 01 (slow crystal) give 2.
- R8: Pin-use register (address 2) bits 1:0 set `ana_pins` (bit n = 1 means pin n is analog). 00 gives 1111. 01 gives 0111 and sets `ext_ref` because pin 3 carries the reference. 10 gives 0011. 11 gives 0000.
- R9: A start write while a conversion is running is ignored. The running conversion finishes at its original edge with the correct result.
- R10: A control write with bit 0 at 0 during a conversion aborts it. Bit 2 reads 0 and the flag and the result register stay unchanged.
- R11: Software can write the result register and read it back. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_mode | input | 2 | Oscillator mode: 00 RC, 01 slow crystal, 10 standard crystal, 11 fast crystal |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 result, 2 pin use |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| cmp_above | input | 1 | Comparator: input at or above the trial level |
| dac_code | output | 8 | Trial code to the DAC |
| chan_sel | output | 2 | Analog multiplexer select |
| ana_pins | output | 4 | Per-pin analog enable |
| ext_ref | output | 1 | Reference is taken from pin 3 |

## Verification
Take the write edge as edge 0. A conversion's results are due at edge 8·N. At that edge the start bit falls, the flag rises and the result is loaded. The bench therefore waits 8·N−1 edges and confirms the start bit is still 1, then waits one more edge and checks the start bit, the flag and the result. It does this for every ratio and for every automatic mode. Register-driven outputs such as `chan_sel`, `ana_pins` and `ext_ref` change at the write edge itself. Reads are combinational. Every sample is therefore taken half a nanosecond after a rising edge, so it sees the state left by that edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int RES_W = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_RES  = 2'd1;
  localparam logic [1:0] ADDR_PIN  = 2'd2;

  localparam logic [1:0] OSC_RC = 2'b00;
  localparam logic [1:0] OSC_LF = 2'b01;
  localparam logic [1:0] OSC_XT = 2'b10;
  localparam logic [1:0] OSC_HF = 2'b11;

  // divider choice after resolving the automatic setting
  localparam logic [1:0] DIV_SEL_FAST = 2'd0;
  localparam logic [1:0] DIV_SEL_MID  = 2'd1;
  localparam logic [1:0] DIV_SEL_SLOW = 2'd2;
  localparam logic [1:0] DIV_SEL_AUTO = 2'd3;

  function automatic logic [1:0] eff_div_sel(logic [1:0] sel, logic [1:0] osc);
    if (sel != DIV_SEL_AUTO) return sel;
    case (osc)
      OSC_HF:  return DIV_SEL_SLOW;
      OSC_XT:  return DIV_SEL_MID;
      default: return DIV_SEL_FAST;
    endcase
  endfunction

  function automatic logic [3:0] pin_mask(logic [1:0] cfg);
    case (cfg)
      2'b00:   return 4'b1111;
      2'b01:   return 4'b0111;
      2'b10:   return 4'b0011;
      default: return 4'b0000;
    endcase
  endfunction

  // one search step: keep or drop the bit under test, then add the next trial bit
  function automatic logic [RES_W-1:0] sar_step(logic [RES_W-1:0] trial,
                                                logic [RES_W-1:0] ptr,
                                                logic keep);
    logic [RES_W-1:0] kept;
    kept = keep ? trial : (trial & ~ptr);
    return kept | (ptr >> 1);
  endfunction

endpackage

// File: rtl/adc_clkdiv.sv
module adc_clkdiv #(
  parameter int DIV_FAST = 2,
  parameter int DIV_MID  = 8,
  parameter int DIV_SLOW = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] div_sel,
  output logic       tick
);
  import adc_seq_pkg::*;

  localparam int CW = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;
  localparam logic [CW-1:0] LIM_FAST = CW'(DIV_FAST - 1);
  localparam logic [CW-1:0] LIM_MID  = CW'(DIV_MID - 1);
  localparam logic [CW-1:0] LIM_SLOW = CW'(DIV_SLOW - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb begin
    case (div_sel)
      DIV_SEL_FAST: lim = LIM_FAST;
      DIV_SEL_MID:  lim = LIM_MID;
      default:      lim = LIM_SLOW;
    endcase
  end

  assign tick = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_sar.sv
module adc_sar #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         abort,
  input  logic         tick,
  input  logic         cmp_above,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] trial,
  output logic [W-1:0] conv_value
);
  import adc_seq_pkg::*;

  localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] ptr;
  logic         last_bit;

  assign last_bit   = ptr[0];
  assign conv_value = cmp_above ? trial : (trial & ~ptr);
  assign done       = busy && tick && last_bit && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ptr   <= '0;
      trial <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      ptr  <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      ptr   <= MSB;
      trial <= MSB;
    end else if (busy && tick) begin
      if (last_bit) begin
        busy  <= 1'b0;
        trial <= conv_value;
      end else begin
        trial <= sar_step(trial, ptr, cmp_above);
      end
      ptr <= ptr >> 1;
    end
  end
endmodule

// File: rtl/adc_regs.sv
module adc_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [1:0]   addr,
  input  logic [7:0]   wdata,
  output logic [7:0]   rdata,
  input  logic         busy,
  input  logic         done,
  input  logic [W-1:0] conv_value,
  output logic         run_bit,
  output logic         flag,
  output logic [1:0]   chan,
  output logic [1:0]   clk_sel,
  output logic [1:0]   pin_cfg,
  output logic         start,
  output logic         abort
);
  import adc_seq_pkg::*;

  logic         gp_bit;
  logic [W-1:0] result;
  logic         wr_ctrl, wr_res, wr_pin;

  assign wr_ctrl = wr && (addr == ADDR_CTRL);
  assign wr_res  = wr && (addr == ADDR_RES);
  assign wr_pin  = wr && (addr == ADDR_PIN);

  assign start = wr_ctrl && wdata[0] && wdata[2] && !busy;
  assign abort = wr_ctrl && !wdata[0] && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_bit <= 1'b0;
      chan    <= 2'b00;
      gp_bit  <= 1'b0;
      clk_sel <= 2'b00;
    end else if (wr_ctrl) begin
      run_bit <= wdata[0];
      chan    <= wdata[4:3];
      gp_bit  <= wdata[5];
      clk_sel <= wdata[7:6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     flag <= 1'b0;
    else if (done)                  flag <= 1'b1;
    else if (wr_ctrl && !wdata[1])  flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      result <= '0;
    else if (done)   result <= conv_value;
    else if (wr_res) result <= wdata[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_cfg <= 2'b00;
    else if (wr_pin) pin_cfg <= wdata[1:0];
  end

  always_comb begin
    case (addr)
      ADDR_CTRL: rdata = {clk_sel, gp_bit, chan, busy, flag, run_bit};
      ADDR_RES:  rdata = 8'(result);
      ADDR_PIN:  rdata = {6'b0, pin_cfg};
      default:   rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int DIV_FAST = 2,
  parameter int DIV_MID  = 8,
  parameter int DIV_SLOW = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] osc_mode,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       cmp_above,
  output logic [7:0] dac_code,
  output logic [1:0] chan_sel,
  output logic [3:0] ana_pins,
  output logic       ext_ref
);
  import adc_seq_pkg::*;

  logic             conv_busy, conv_done, conv_start, conv_abort;
  logic             run_bit, irq_flag, div_tick;
  logic [1:0]       clk_sel, pin_cfg, div_sel;
  logic [RES_W-1:0] conv_value;

  assign div_sel  = eff_div_sel(clk_sel, osc_mode);
  assign ana_pins = pin_mask(pin_cfg);
  assign ext_ref  = (pin_cfg == 2'b01);

  adc_regs #(.W(RES_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(conv_busy), .done(conv_done), .conv_value(conv_value),
    .run_bit(run_bit), .flag(irq_flag), .chan(chan_sel), .clk_sel(clk_sel),
    .pin_cfg(pin_cfg), .start(conv_start), .abort(conv_abort)
  );

  adc_clkdiv #(.DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(conv_start || !conv_busy),
    .div_sel(div_sel), .tick(div_tick)
  );

  adc_sar #(.W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .start(conv_start), .abort(conv_abort),
    .tick(div_tick), .cmp_above(cmp_above), .busy(conv_busy), .done(conv_done),
    .trial(dac_code), .conv_value(conv_value)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       abort,
  input logic       run_bit,
  input logic       flag,
  input logic [7:0] dac_code,
  input logic       ext_ref,
  input logic [3:0] ana_pins
);
  p_busy_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_bit);

  p_msb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> dac_code == 8'h80);

  p_done_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_done_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag);

  p_ref_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ref |-> ana_pins == 4'b0111);

  p_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !abort) |=> busy);

  p_abort_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

  p_abort_no_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !flag) |=> !flag);
endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(conv_busy), .done(conv_done), .abort(conv_abort),
  .run_bit(run_bit), .flag(irq_flag), .dac_code(dac_code), .ext_ref(ext_ref),
  .ana_pins(ana_pins)
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/100ps
module adc_seq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] osc_mode = 2'b00;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'b00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       cmp_above;
  logic [7:0] dac_code;
  logic [1:0] chan_sel;
  logic [3:0] ana_pins;
  logic       ext_ref;
  logic [7:0] vin = 8'h00;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  // behavioural comparator: input at or above the trial level
  assign cmp_above = (vin >= dac_code);

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .osc_mode(osc_mode), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmp_above(cmp_above), .dac_code(dac_code), .chan_sel(chan_sel),
    .ana_pins(ana_pins), .ext_ref(ext_ref)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #0.5;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #0.5;
  endtask

  // start a conversion and check the exact edge on which it completes
  task automatic convert(input logic [7:0] v, input logic [1:0] sel,
                         input logic [1:0] osc, input int n, input string tag);
    logic [7:0] d;
    vin = v; osc_mode = osc;
    wr(2'd0, {sel, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1});
    edges(8*n - 1);
    rd(2'd0, d); chk(d[2] == 1'b1, {tag, " busy before end"}, d[2], 1);
    edges(1);
    rd(2'd0, d); chk(d[2] == 1'b0, {tag, " go cleared"}, d[2], 0);
    chk(d[1] == 1'b1, {tag, " R4 flag set"}, d[1], 1);
    rd(2'd1, d); chk(d == v, {tag, " result"}, d, v);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); chk(d == 8'h00, "R1 ctrl", d, 0);
    rd(2'd1, d); chk(d == 8'h00, "R1 result", d, 0);
    rd(2'd2, d); chk(d == 8'h00, "R1 pin cfg", d, 0);
    chk(dac_code == 8'h00, "R1 dac", dac_code, 0);
    chk(ana_pins == 4'hF && !ext_ref, "R1 pins", {ext_ref, ana_pins}, 8'h0F);
  endtask

  task automatic t_run_off;
    logic [7:0] d;
    vin = 8'h40;
    wr(2'd0, 8'h04);
    edges(40);
    rd(2'd0, d); chk(d == 8'h00, "R2 no start without enable", d, 0);
  endtask

  task automatic t_ratios;
    convert(8'h00, 2'b00, 2'b00, 2,  "R3 R6 div2 zero");
    convert(8'hFF, 2'b00, 2'b00, 2,  "R3 R6 div2 full");
    convert(8'hA5, 2'b01, 2'b00, 8,  "R3 R6 div8");
    convert(8'h5A, 2'b10, 2'b00, 32, "R3 R6 div32");
    convert(8'h80, 2'b00, 2'b00, 2,  "R3 mid code");
  endtask

  task automatic t_auto;
    convert(8'h13, 2'b11, 2'b00, 2,  "R7 auto rc");
    convert(8'h31, 2'b11, 2'b01, 2,  "R7 auto slow xtal");
    convert(8'hC7, 2'b11, 2'b10, 8,  "R7 auto std xtal");
    convert(8'h7E, 2'b11, 2'b11, 32, "R7 auto fast xtal");
  endtask

  task automatic t_flag;
    logic [7:0] d;
    wr(2'd0, 8'b0000_0011);
    rd(2'd0, d); chk(d[1] == 1'b1, "R4 write one keeps flag", d[1], 1);
    wr(2'd0, 8'b0000_0001);
    rd(2'd0, d); chk(d[1] == 1'b0, "R4 write zero clears", d[1], 0);
  endtask

  task automatic t_chan;
    logic [7:0] d;
    wr(2'd0, 8'b0011_0001);
    chk(chan_sel == 2'd2, "R5 chan out", chan_sel, 2);
    rd(2'd0, d); chk(d[5:3] == 3'b110, "R5 chan and gp readback", d[5:3], 6);
    wr(2'd0, 8'b0001_1001);
    chk(chan_sel == 2'd3, "R5 chan three", chan_sel, 3);
    rd(2'd0, d); chk(d[5] == 1'b0, "R5 gp cleared", d[5], 0);
  endtask

  task automatic t_pins;
    logic [7:0] d;
    for (int c = 0; c < 4; c++) begin
      logic [3:0] em;
      em = (c == 0) ? 4'b1111 : (c == 1) ? 4'b0111 : (c == 2) ? 4'b0011 : 4'b0000;
      wr(2'd2, 8'(c));
      chk(ana_pins == em, "R8 pin mask", ana_pins, em);
      chk(ext_ref == (c == 1), "R8 ext ref", ext_ref, (c == 1));
      rd(2'd2, d); chk(d == 8'(c), "R8 readback", d, c);
    end
    wr(2'd2, 8'h00);
  endtask

  task automatic t_go_busy;
    logic [7:0] d;
    vin = 8'h3C; osc_mode = 2'b00;
    wr(2'd0, 8'b0100_0101);
    edges(19);
    wr(2'd0, 8'b0100_0101);
    edges(64 - 20 - 1);
    rd(2'd0, d); chk(d[2] == 1'b1, "R9 still busy", d[2], 1);
    edges(1);
    rd(2'd0, d); chk(d[2] == 1'b0, "R9 ends on original edge", d[2], 0);
    rd(2'd1, d); chk(d == 8'h3C, "R9 result", d, 8'h3C);
  endtask

  task automatic t_abort;
    logic [7:0] d;
    wr(2'd0, 8'b0100_0001);
    vin = 8'h77;
    wr(2'd0, 8'b0100_0101);
    edges(10);
    wr(2'd0, 8'b0100_0000);
    edges(300);
    rd(2'd0, d); chk(d[2:0] == 3'b000, "R10 aborted, flag clear", d[2:0], 0);
    rd(2'd1, d); chk(d == 8'h3C, "R10 result unchanged", d, 8'h3C);
  endtask

  task automatic t_result_rw;
    logic [7:0] d;
    wr(2'd1, 8'h69);
    rd(2'd1, d); chk(d == 8'h69, "R11 result write", d, 8'h69);
    rd(2'd3, d); chk(d == 8'h00, "R11 unused address", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #0.5;
    t_reset();
    rst_n = 1'b1;
    edges(2);
    t_reset();
    t_run_off();
    t_ratios();
    t_auto();
    t_flag();
    t_chan();
    t_pins();
    t_go_busy();
    t_abort();
    t_result_rw();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule